// File: doc/BRIEF.md
# Bit-Serial Symmetric FIR Pre-Adder Front End

This block is the input stage of a distributed-arithmetic FIR filter with 32 even-symmetric taps. It accepts parallel 16-bit two's-complement samples, widens each one to 17 bits by copying the sign, and keeps a window of the newest sample plus the 31 samples before it. Because the coefficients mirror around the centre, the taps at positions p and 31-p share one coefficient. For each of these 16 pairs, a bit-serial adder sums the two samples. The adder is a full adder with a carry flip-flop.

Once a sample is taken, the block runs one 17-cycle word. In each bit cycle it presents one 16-bit address vector, whose bit p is the current serial sum bit of pair p. Bits run from least to most significant. The word's first bit and its final (sign) bit are flagged. A downstream lookup-table and shift-accumulate stage takes one address per handshake.

Both sides are valid/ready streams. The output holds its address, flags and bit position for as long as `out_ready` is low. A new input sample is accepted only at a word boundary: when the block is idle, or in the same cycle that the sign bit of the current word is taken downstream. This means back-to-back words flow with no idle cycle between them.

Top module: `symfir_serial_front`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, `out_addr` is all zeros, and every delay stage holds zero.
- R2: For each pair p (0..15), the 17 bits a word shows on `out_addr[p]` form the value sext17(x[n-p]) + sext17(x[n-31+p]) modulo 2^17. Here x[n] is the newest accepted sample, tap 0 is the newest, and sext17 copies bit 15 into bit 16.
- R3: The k-th output handshake of a word (k = 0..16) carries bit k of each pair sum, so the least significant bit comes first.
- R4: `out_first` is 1 exactly on bit 0 of a word and `out_last` is 1 exactly on bit 16. Each word is 17 handshakes long.
- R5: Every accepted sample moves the window by exactly one position. Samples that are not yet present count as zero, and the window does not change between accepts.
- R6: `in_ready` is 0 while a word is in progress, except during its bit-16 handshake. When `in_ready` is 0, `in_valid` and `in_sample` have no effect.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_addr`, `out_first`, `out_last` and the bit position stay unchanged.
- R8: Each pair adder starts every word with a cleared carry, so full-scale inputs (both -32768, or both 32767) give exact sums of -65536 and 65534.
- R9: A sample accepted during the bit-16 handshake starts its word in the next cycle, so bit 0 of the new word follows bit 16 of the old one with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Two's-complement input sample |
| out_valid | output | 1 | Address vector valid |
| out_ready | input | 1 | Downstream takes the address this cycle |
| out_addr | output | 16 | One pre-added serial bit per symmetric pair |
| out_first | output | 1 | Bit 0 of a word |
| out_last | output | 1 | Bit 16 (sign) of a word |

## Verification
Two kinds of internal fault show up at the output in different ways:
- A carry that is not cleared between words corrupts bit 0 of the next word at once.
- A delay stage that shifts wrongly, or not at all, affects a pair address bit within one word. The impulse phase isolates each pair in turn, so a single wrong stage stands out.

A bit counter that slips or skips shows up at the ports within one cycle as a misplaced `out_first` or `out_last`, or as an `in_ready` that opens mid-word. Each cycle the bench compares every output bit and `in_ready` with an integer model of the window. At each sign bit it also rebuilds every 17-bit word. Stall patterns, input gaps and full-scale values expose faults in hold behaviour and carry.

// File: rtl/symfir_fe_pkg.sv
package symfir_fe_pkg;

  // Word-level control state of the serialiser
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } fe_state_e;

  // Index of the mirror tap for a symmetric pair
  function automatic int unsigned pair_mate(int unsigned p, int unsigned taps);
    return taps - 1 - p;
  endfunction

endpackage

// File: rtl/symfir_fe_ctrl.sv
module symfir_fe_ctrl #(
  parameter int unsigned EXT_W = 17,
  localparam int unsigned IDX_W = $clog2(EXT_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             accept,
  output logic             bit_adv,
  output logic             busy,
  output logic [IDX_W-1:0] bit_idx,
  output logic             word_start,
  output logic             word_last
);
  import symfir_fe_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(EXT_W - 1);

  fe_state_e state_q;

  assign busy       = (state_q == ST_SHIFT);
  assign word_start = busy && (bit_idx == '0);
  assign word_last  = busy && (bit_idx == LAST_IDX);
  assign bit_adv    = busy && out_ready;
  assign in_ready   = !busy || (bit_adv && word_last);
  assign accept     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_idx <= '0;
    end else if (accept) begin
      state_q <= ST_SHIFT;
      bit_idx <= '0;
    end else if (bit_adv) begin
      if (word_last) begin
        state_q <= ST_IDLE;
        bit_idx <= '0;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end

  // R4: position never leaves the word
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bit_idx <= LAST_IDX));

  // R9: an accepted sample opens a word on the next cycle
  assert_start_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> word_start);

  // R7: stalled output keeps its position
  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !out_ready) |=> (busy && $stable(bit_idx)));

  // R6: no acceptance in the middle of a word
  assert_no_midword_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_last) |-> !in_ready);

endmodule

// File: rtl/symfir_fe_window.sv
module symfir_fe_window #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned TAPS     = 32,
  localparam int unsigned EXT_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [EXT_W-1:0]    taps [TAPS]
);

  // Stage 0 is the current sample (serialiser source); 1..TAPS-1 is the delay line
  for (genvar k = 0; k < TAPS; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        taps[k] <= '0;
      end else if (accept) begin
        if (k == 0) begin
          taps[k] <= {sample[SAMPLE_W-1], sample};
        end else begin
          taps[k] <= taps[k-1];
        end
      end
    end
  end

  // R5: window moves by exactly one stage per accept
  assert_shift_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (taps[TAPS-1] == $past(taps[TAPS-2])));

  // R5: window is frozen between accepts
  assert_hold_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(taps[1]));

  // R2: the stored current sample is sign-extended
  assert_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taps[0][EXT_W-1] == taps[0][EXT_W-2]);

endmodule

// File: rtl/symfir_fe_pair_add.sv
module symfir_fe_pair_add (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_a,
  input  logic bit_b,
  input  logic accept,
  input  logic bit_adv,
  input  logic word_start,
  input  logic word_last,
  output logic sum_bit
);

  logic carry_q;
  logic carry_d;

  assign sum_bit = bit_a ^ bit_b ^ carry_q;
  assign carry_d = (bit_a & bit_b) | (carry_q & (bit_a ^ bit_b));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
    end else if (accept) begin
      carry_q <= 1'b0;
    end else if (bit_adv) begin
      carry_q <= word_last ? 1'b0 : carry_d;
    end
  end

  // R8: each word begins with a cleared carry
  assert_carry_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    word_start |-> !carry_q);

endmodule

// File: rtl/symfir_serial_front.sv
module symfir_serial_front #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned TAPS     = 32,
  localparam int unsigned EXT_W   = SAMPLE_W + 1,
  localparam int unsigned PAIRS   = TAPS / 2,
  localparam int unsigned IDX_W   = $clog2(EXT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [PAIRS-1:0]    out_addr,
  output logic                out_first,
  output logic                out_last
);
  import symfir_fe_pkg::*;

  logic             accept;
  logic             bit_adv;
  logic             busy;
  logic [IDX_W-1:0] bit_idx;
  logic             word_start;
  logic             word_last;
  logic [EXT_W-1:0] taps [TAPS];
  logic [PAIRS-1:0] sums;

  symfir_fe_ctrl #(.EXT_W(EXT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .in_ready   (in_ready),
    .accept     (accept),
    .bit_adv    (bit_adv),
    .busy       (busy),
    .bit_idx    (bit_idx),
    .word_start (word_start),
    .word_last  (word_last)
  );

  symfir_fe_window #(.SAMPLE_W(SAMPLE_W), .TAPS(TAPS)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .sample (in_sample),
    .taps   (taps)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int unsigned MATE = pair_mate(p, TAPS);
    symfir_fe_pair_add u_add (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_a      (taps[p][bit_idx]),
      .bit_b      (taps[MATE][bit_idx]),
      .accept     (accept),
      .bit_adv    (bit_adv),
      .word_start (word_start),
      .word_last  (word_last),
      .sum_bit    (sums[p])
    );
  end

  assign out_valid = busy;
  assign out_first = word_start;
  assign out_last  = word_last;
  assign out_addr  = busy ? sums : '0;

  // R7: stalled address vector and flags are held at the port
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                   && $stable(out_first) && $stable(out_last)));

  // R4: first and last flags never coincide
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_first && out_last));

endmodule

// File: tb/tb_symfir_serial_front.sv
`timescale 1ns/1ps
module tb_symfir_serial_front;

  localparam int TAPS = 32;
  localparam int PAIRS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_sample = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_addr;
  logic        out_first;
  logic        out_last;

  always #2 clk = ~clk;

  symfir_serial_front dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_first(out_first), .out_last(out_last)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // behavioural model
  logic signed [15:0] hist [TAPS];
  bit   busy_m = 1'b0;
  int   cnt_m = 0;
  logic [16:0] rebuilt [PAIRS];
  logic signed [15:0] q [$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [16:0] pair_word(int p);
    int s;
    s = int'(hist[p]) + int'(hist[TAPS-1-p]);
    return s[16:0];
  endfunction

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] next_lfsr(logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic step(bit want_valid, bit ordy);
    bit fire_in, fire_out, exp_rdy;
    logic [15:0] exp_addr;
    @(negedge clk);
    lfsr = next_lfsr(lfsr);
    in_valid  = want_valid && (q.size() > 0);
    in_sample = (q.size() > 0) ? q[0] : lfsr;
    out_ready = ordy;
    #1;
    exp_rdy = !busy_m || (ordy && cnt_m == 16);
    check("R6", "in_ready", in_ready, exp_rdy);
    check("R4", "out_valid", out_valid, busy_m);
    check("R4", "out_first", out_first, busy_m && cnt_m == 0);
    check("R4", "out_last", out_last, busy_m && cnt_m == 16);
    exp_addr = '0;
    if (busy_m)
      for (int p = 0; p < PAIRS; p++) begin
        logic [16:0] w;
        w = pair_word(p);
        exp_addr[p] = w[cnt_m];
      end
    check(ordy ? "R3" : "R7", "out_addr", out_addr, exp_addr);
    fire_out = busy_m && ordy;
    fire_in  = in_valid && exp_rdy;
    @(posedge clk);
    if (fire_out) begin
      for (int p = 0; p < PAIRS; p++) rebuilt[p][cnt_m] = out_addr[p];
      if (cnt_m == 16) begin
        for (int p = 0; p < PAIRS; p++)
          check("R2", $sformatf("pair%0d word", p), rebuilt[p], pair_word(p));
        busy_m = 1'b0;
        cnt_m = 0;
      end else begin
        cnt_m++;
      end
    end
    if (fire_in) begin
      for (int k = TAPS - 1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = q.pop_front();
      busy_m = 1'b1;
      cnt_m = 0;
    end
  endtask

  task automatic drain(int mode);
    int guard = 0;
    while ((q.size() > 0 || busy_m) && guard < 20000) begin
      case (mode)
        0: step(1'b1, 1'b1);
        1: step(lfsr[3] | lfsr[7], lfsr[0] | lfsr[5]);
        default: step(lfsr[2], 1'b1);
      endcase
      guard++;
    end
    step(1'b0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TAPS; k++) hist[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "out_valid", out_valid, 0);
    check("R1", "in_ready", in_ready, 1);
    check("R1", "out_addr", out_addr, 0);

    // R5: zero-filled window, then an impulse walking through all pairs; R9 back-to-back
    q.push_back(16'sd1234);
    for (int i = 0; i < 33; i++) q.push_back(16'sd0);
    drain(0);

    // R8: full-scale values, same and opposite signs
    for (int i = 0; i < 34; i++) q.push_back(-16'sd32768);
    for (int i = 0; i < 34; i++) q.push_back(16'sd32767);
    for (int i = 0; i < 20; i++) q.push_back(i[0] ? 16'sd32767 : -16'sd32768);
    drain(0);

    // R6 R7: pseudo-random data with input gaps and output stalls
    for (int i = 0; i < 60; i++) begin
      lfsr = next_lfsr(lfsr);
      q.push_back(lfsr);
    end
    drain(1);

    // R5: input gaps with output always ready
    for (int i = 0; i < 20; i++) q.push_back(16'(i * 1111 - 9000));
    drain(2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule